// File: doc/BRIEF.md
# Keyed-Enable Watchdog Timer

This block is a watchdog for a small microcontroller core. It monitors the core's register write port and watches one write-only refresh register. After a system reset it stays idle. Software starts it by writing a fixed two-byte key to the refresh register, and keeps it alive by writing the same key again before the count runs out.

Once started, a cycle counter advances on every machine-cycle tick. If software does not rewrite the key in time, the counter passes the top of its range. The block then raises a one-cycle CPU reset request and returns to its idle state.

Software has no way to stop the watchdog. Only the reset the watchdog causes, or an external reset, takes it back to idle.

Top module: `wdog_keyed`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `armed` and `cpu_rst_req` are both 0.
- R2: A key is two writes to the refresh address: data 0x1E, then data 0xE1. When they are consecutive writes to that address, `armed` is 1 from the next cycle and the count starts at zero.
- R3: A write of 0xE1 does not arm the block unless the previous write to the refresh address carried 0x1E. If any other value was written to that address in between, the key is broken.
- R4: Writes whose address differs from `refresh_addr` have no effect on key tracking. The sequence 0x1E, a write of 0x77 elsewhere, then 0xE1 still arms the block.
- R5: The count advances only on cycles where `cyc_tick` is 1 and the block is armed. While disarmed, ticks do nothing.
- R6: Counting from the key write, the 16384th tick overflows the 14-bit count. On the next cycle, `cpu_rst_req` is 1 for exactly one cycle and `armed` is 0.
- R7: Writing the key again while armed restarts the count from zero, so another full 16384 ticks are needed before a reset request.
- R8: While armed, writes of any non-key value to the refresh address never clear `armed`. Only an overflow clears it.
- R9: A watchdog overflow also forgets the last refresh value. A 0xE1 written after an overflow does not arm the block, even if 0x1E was the last value written before the overflow.
- R10: If the key completes in the same cycle as a tick, the key wins: the count is zero afterwards and no reset request follows from that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_tick | input | 1 | Machine-cycle tick, one clock wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (8) | Register write address |
| wr_data | input | 8 | Register write data |
| refresh_addr | input | AW (8) | Address of the refresh register |
| cpu_rst_req | output | 1 | One-cycle CPU reset request |
| armed | output | 1 | Watchdog running |

## Verification
Key handling is tried with four write patterns:
- a lone 0xE1;
- 0x1E followed by a different value and then 0xE1;
- 0x1E followed by a write to a foreign address and then 0xE1;
- the clean pair.

Together these separate "previous write to this register" from "previous write on the bus". Timeouts are run twice: once with a tick every cycle and once with a tick every other cycle. In both runs the bench shows that the reset request lands exactly 16384 ticks after the last key. The run also includes a key written in the same cycle as a tick, and a key left half-written across an overflow.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned KEY_W = 8;
  localparam logic [KEY_W-1:0] KEY_FIRST  = 8'h1E;
  localparam logic [KEY_W-1:0] KEY_SECOND = 8'hE1;
endpackage

// File: rtl/wdog_key_track.sv
module wdog_key_track
  import wdog_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [KEY_W-1:0] wr_data,
  input  logic [AW-1:0]    ref_addr,
  input  logic             clr,
  output logic             key_ok
);
  logic [KEY_W-1:0] last_q;
  logic             hit;

  assign hit    = wr_en && (wr_addr == ref_addr);
  assign key_ok = hit && (wr_data == KEY_SECOND) && (last_q == KEY_FIRST);

  always_ff @(posedge clk) begin
    if (rst)      last_q <= '0;
    else if (clr) last_q <= '0;
    else if (hit) last_q <= wr_data;
  end

  // R4: foreign writes leave the remembered value untouched
  a_r4_foreign_write: assert property (@(posedge clk) disable iff (rst)
    (!hit && !clr) |=> $stable(last_q));
  // R9: overflow wipes the remembered refresh value
  a_r9_clear_on_wrap: assert property (@(posedge clk) disable iff (rst)
    clr |=> (last_q == '0));
endmodule

// File: rtl/wdog_cycle_cnt.sv
module wdog_cycle_cnt #(
  parameter int unsigned CNT_W = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic key_ok,
  output logic wrap,
  output logic armed,
  output logic rst_req
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q, req_q;

  assign wrap    = armed_q && tick && !key_ok && (cnt_q == CNT_MAX);
  assign armed   = armed_q;
  assign rst_req = req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      req_q   <= 1'b0;
    end else begin
      req_q <= wrap;
      if (key_ok) begin
        armed_q <= 1'b1;
        cnt_q   <= '0;
      end else if (wrap) begin
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else if (armed_q && tick) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R1: reset leaves the block idle
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!armed_q && !req_q));
  // R2 / R7 / R10: a key always lands armed with a zero count
  a_r2_key_zero: assert property (@(posedge clk) disable iff (rst)
    key_ok |=> (armed_q && cnt_q == '0 && !req_q));
  // R5: one step per tick while armed
  a_r5_count_step: assert property (@(posedge clk) disable iff (rst)
    (armed_q && tick && !key_ok && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R6: the request is one cycle wide and the block is idle with it
  a_r6_req_single: assert property (@(posedge clk) disable iff (rst)
    req_q |=> !req_q);
  a_r6_req_disarmed: assert property (@(posedge clk) disable iff (rst)
    req_q |-> !armed_q);
  // R8: disarming only happens through an overflow
  a_r8_no_soft_disarm: assert property (@(posedge clk) disable iff (rst)
    $fell(armed_q) |-> req_q);
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int unsigned AW    = 8,
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_tick,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [KEY_W-1:0] wr_data,
  input  logic [AW-1:0]    refresh_addr,
  output logic             cpu_rst_req,
  output logic             armed
);
  logic key_ok, wrap;

  wdog_key_track #(.AW(AW)) u_track (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .ref_addr (refresh_addr),
    .clr      (wrap),
    .key_ok   (key_ok)
  );

  wdog_cycle_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick    (cyc_tick),
    .key_ok  (key_ok),
    .wrap    (wrap),
    .armed   (armed),
    .rst_req (cpu_rst_req)
  );
endmodule

// File: tb/tb_wdog_keyed.sv
`timescale 1ns/1ps
module tb_wdog_keyed;
  localparam int LIMIT = 16384;
  localparam logic [7:0] REF = 8'hA6;

  logic clk = 0, rst = 1, cyc_tick = 0, wr_en = 0;
  logic [7:0] wr_addr = 0, wr_data = 0, refresh_addr = REF;
  logic cpu_rst_req, armed;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wdog_keyed dut (
    .clk(clk), .rst(rst), .cyc_tick(cyc_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .refresh_addr(refresh_addr),
    .cpu_rst_req(cpu_rst_req), .armed(armed)
  );

  // behavioural reference
  bit m_armed = 0, m_req = 0;
  int m_cnt = 0, m_since = 0;
  int m_last = 0;
  always @(posedge clk) begin
    bit hit, key, ovf;
    if (rst) begin
      m_armed = 0; m_req = 0; m_cnt = 0; m_last = 0; m_since = 0;
    end else begin
      hit = wr_en && (wr_addr == refresh_addr);
      key = hit && wr_data == 8'hE1 && m_last == 8'h1E;
      ovf = m_armed && cyc_tick && !key && (m_cnt + 1 == LIMIT);
      m_req = ovf;
      if (m_armed && cyc_tick && !key) m_since++;
      if (key) begin m_armed = 1; m_cnt = 0; m_since = 0; end
      else if (ovf) begin m_armed = 0; m_cnt = 0; end
      else if (m_armed && cyc_tick) m_cnt++;
      if (ovf) m_last = 0;
      else if (hit) m_last = wr_data;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // compare every cycle, away from the edge
  always @(posedge clk) begin
    #1;
    if (!done) begin
      chk(armed === m_armed, "R2/R8 armed vs model", armed, m_armed);
      chk(cpu_rst_req === m_req, "R6 cpu_rst_req vs model", cpu_rst_req, m_req);
      if (cpu_rst_req === 1'b1)
        chk(m_since == LIMIT, "R6 ticks before request", m_since, LIMIT);
    end
  end

  task automatic step(input bit we, input logic [7:0] a, input logic [7:0] d, input bit tk);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; cyc_tick = tk;
  endtask

  task automatic idle(input int n, input bit tk);
    for (int i = 0; i < n; i++) step(0, 0, 0, tk);
  endtask

  task automatic settle;
    @(posedge clk); #1.5;
  endtask

  task automatic run_out(input int gap, output int req_seen);
    req_seen = 0;
    for (int i = 0; i < 3 * LIMIT && req_seen == 0; i++) begin
      step(0, 0, 0, (i % gap) == 0);
      settle();
      if (cpu_rst_req) req_seen = 1;
    end
  endtask

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    settle();
    chk(armed === 0 && cpu_rst_req === 0, "R1 idle in reset", armed, 0);
    @(negedge clk); rst = 0;
    settle();
    chk(armed === 0, "R1 idle after reset", armed, 0);

    idle(20, 1); settle();
    chk(armed === 0, "R5 ticks ignored while idle", armed, 0);

    step(1, REF, 8'hE1, 0); step(0, 0, 0, 0); settle();
    chk(armed === 0, "R3 lone second byte", armed, 0);
    step(1, REF, 8'h1E, 0); step(1, REF, 8'h55, 0); step(1, REF, 8'hE1, 0);
    step(0, 0, 0, 0); settle();
    chk(armed === 0, "R3 broken pair", armed, 0);

    step(1, REF, 8'h1E, 0); step(1, 8'h10, 8'h77, 0); step(1, REF, 8'hE1, 0);
    step(0, 0, 0, 0); settle();
    chk(armed === 1, "R4 foreign write between key bytes", armed, 1);

    idle(100, 1);
    step(1, REF, 8'h1E, 1); step(1, REF, 8'hE1, 1);   // R7 rekey, R10 with tick
    step(1, REF, 8'h00, 1); step(1, REF, 8'hFF, 1);   // R8 stray refresh values
    step(1, REF, 8'h1E, 1);                            // R9 half key before overflow
    settle();
    chk(armed === 1, "R8 stray writes keep armed", armed, 1);
    run_out(1, seen);
    chk(seen == 1, "R6 request after full count", seen, 1);
    settle();
    chk(cpu_rst_req === 0 && armed === 0, "R6 single pulse, idle", cpu_rst_req, 0);

    step(1, REF, 8'hE1, 0); step(0, 0, 0, 0); settle();
    chk(armed === 0, "R9 half key forgotten on overflow", armed, 0);

    step(1, REF, 8'h1E, 0); step(1, REF, 8'hE1, 0); step(0, 0, 0, 0); settle();
    chk(armed === 1, "R2 clean key arms", armed, 1);
    run_out(2, seen);
    chk(seen == 1, "R5 sparse ticks reach request", seen, 1);
    idle(4, 0); settle();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule